// File: doc/BRIEF.md
# Block-Loaded Receive Word FIFO with Ping-Pong Buffers

This block is the receive path of a 16-bit parallel input port. Words arriving from the pad side are packed into two alternating 128-bit staging buffers. When a staging buffer is complete, and only while the eight-word read FIFO is empty, the buffer is moved into the FIFO in one wide copy. A processor-side data register then drains the FIFO one word per read, oldest first, with an optional exchange of the two bytes of each word.

A transfer begins with a start pulse that programs the number of words expected. When that count is reached, the end-of-transfer flag rises. A final buffer that is only partly filled is still treated as complete, so a short tail reaches the reader. A read issued while the FIFO has not been loaded holds the reader through a stall output until the load happens. Software may abandon unread words with a clear strobe, which only acts once the transfer has ended. The most recent pad word is kept on a separate tap for a redundancy generator.

Top module: `rx_block_fifo`

## Requirements
- R1: After reset full_o is 0, stall_o is 0, eoc_o is 1 (idle) and pad_ready_o is 0.
- R2: When a staging buffer completes and the FIFO is empty, full_o stays 0 in the cycle after the accepting edge and is 1 one cycle later, with all eight words loaded at once.
- R3: Each accepted read (rd_i high while full_o is 1) returns the next word in arrival order. The eighth read makes full_o 0 at the next cycle.
- R4: A completed buffer is copied only while the FIFO is empty. Words staged while the FIFO holds data do not disturb the words being read.
- R5: With swap_i at 1, rd_data_o returns the word with its upper byte (bits 15:8) and lower byte (bits 7:0) exchanged. With swap_i at 0, the word is returned unchanged.
- R6: rd_i high while full_o is 0 raises stall_o in the same cycle. stall_o falls in the cycle full_o rises, and that read completes with the first word of the block.
- R7: For a transfer length that is not a multiple of 8, the last partial buffer is loaded into the FIFO. eoc_o is 0 during the transfer and is 1 in the cycle after the last programmed word is accepted.
- R8: clr_i with eoc_o at 1 makes full_o 0 at the next cycle, after which a read stalls. clr_i with eoc_o at 0 has no effect: full_o stays 1 and the next read returns the next word.
- R9: last_word_o equals the most recently accepted pad word, from the cycle after its acceptance.
- R10: pad_ready_o is 0 when the staging buffer at the write pointer is full and not being copied, and also after eoc_o rises. A buffer accepts pad words again in the same cycle its contents are copied.
- R11: The buffers are filled and copied in strict alternation starting at buffer 0. When both are full with the FIFO empty, the one next in turn is copied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer; resets staging pointers and word count |
| len_i | input | 16 | Number of words in the transfer (at least 1), sampled on start_i |
| pad_valid_i | input | 1 | Pad word present |
| pad_data_i | input | 16 | Pad word |
| pad_ready_o | output | 1 | Pad word accepted on this edge when valid |
| rd_i | input | 1 | Data register read request, held until not stalled |
| swap_i | input | 1 | Exchange the bytes of returned words |
| clr_i | input | 1 | Clear strobe for the FIFO status |
| rd_data_o | output | 16 | Word returned to the reader |
| stall_o | output | 1 | Reader must hold; FIFO not loaded |
| full_o | output | 1 | FIFO holds a loaded block |
| eoc_o | output | 1 | Programmed word count received (1 when idle) |
| last_word_o | output | 16 | Most recent pad word, for redundancy logic |

## Verification
The hardest state to reach is both staging buffers full while the FIFO still holds an unread block. That is the only condition in which pad_ready_o is held low mid-transfer, and the only one in which the round-robin choice between two ready buffers can be observed. The bench gets there by pushing 24 words of a 32-word transfer before any read. It then drains the first block and checks, in the single cycle between the last read and the next load, that the freed buffer reopens to the pad side. A second state, a read already stalled when a short final block lands, is reached by running the reader and the pad pusher in parallel.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  localparam int NUM_BUFS = 2;

  function automatic logic rr_next(input logic sel);
    return ~sel;
  endfunction
endpackage

// File: rtl/rbf_pad_fill.sv
module rbf_pad_fill
  import rbf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [CNT_W-1:0]               len_i,
  input  logic                           pad_valid_i,
  input  logic [WORD_W-1:0]              pad_data_i,
  output logic                           pad_ready_o,
  input  logic                           take_i,
  output logic [DEPTH-1:0][WORD_W-1:0]   blk_o,
  output logic                           blk_rdy_o,
  output logic                           eoc_o,
  output logic [WORD_W-1:0]              last_word_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][WORD_W-1:0] buf_q [NUM_BUFS];
  logic [NUM_BUFS-1:0] bfull_q, bfull_d;
  logic                wsel_q, rsel_q;
  logic [IDX_W-1:0]    widx_q;
  logic [CNT_W-1:0]    cnt_q, len_q;
  logic                eoc_q;
  logic [WORD_W-1:0]   last_q;
  logic                accept, final_w, close_w;

  // buffer being copied is free for pad writes in the same cycle
  assign pad_ready_o = ~eoc_q & (~bfull_q[wsel_q] | (take_i & (rsel_q == wsel_q)));
  assign accept      = pad_valid_i & pad_ready_o;
  assign final_w     = (cnt_q + 1'b1) == len_q;
  assign close_w     = accept & ((widx_q == IDX_W'(DEPTH - 1)) | final_w);

  always_comb begin
    bfull_d = bfull_q;
    if (take_i)  bfull_d[rsel_q] = 1'b0;
    if (close_w) bfull_d[wsel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bfull_q <= '0;
      wsel_q  <= 1'b0;
      rsel_q  <= 1'b0;
      widx_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      eoc_q   <= 1'b1;
      last_q  <= '0;
    end else if (start_i) begin
      bfull_q <= '0;
      wsel_q  <= 1'b0;
      rsel_q  <= 1'b0;
      widx_q  <= '0;
      cnt_q   <= '0;
      len_q   <= len_i;
      eoc_q   <= 1'b0;
    end else begin
      bfull_q <= bfull_d;
      if (take_i) rsel_q <= rr_next(rsel_q);
      if (accept) begin
        last_q <= pad_data_i;
        cnt_q  <= cnt_q + 1'b1;
        widx_q <= close_w ? '0 : widx_q + 1'b1;
        if (close_w) wsel_q <= rr_next(wsel_q);
        if (final_w) eoc_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept && !start_i) buf_q[wsel_q][widx_q] <= pad_data_i;
  end

  assign blk_o       = buf_q[rsel_q];
  assign blk_rdy_o   = bfull_q[rsel_q];
  assign eoc_o       = eoc_q;
  assign last_word_o = last_q;

  p_take_from_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> bfull_q[rsel_q]);

  p_close_on_final_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && final_w && !start_i) |=> (eoc_q && bfull_q[$past(wsel_q)]));

  p_last_tap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !start_i) |=> (last_q == $past(pad_data_i)));

  p_rr_take_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i) |=> (rsel_q != $past(rsel_q)));
endmodule

// File: rtl/rbf_read_port.sv
module rbf_read_port #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DEPTH-1:0][WORD_W-1:0] blk_i,
  input  logic                         blk_rdy_i,
  output logic                         take_o,
  input  logic                         rd_i,
  input  logic                         swap_i,
  input  logic                         clr_i,
  input  logic                         eoc_i,
  output logic [WORD_W-1:0]            rd_data_o,
  output logic                         stall_o,
  output logic                         full_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int HALF  = WORD_W / 2;

  logic [DEPTH-1:0][WORD_W-1:0] fifo_q;
  logic [IDX_W-1:0]             ridx_q;
  logic                         full_q;
  logic                         rd_ok, clr_ok;
  logic [WORD_W-1:0]            word;

  assign take_o  = blk_rdy_i & ~full_q;
  assign rd_ok   = rd_i & full_q;
  assign stall_o = rd_i & ~full_q;
  assign clr_ok  = clr_i & eoc_i;
  assign word    = fifo_q[ridx_q];

  always_comb begin
    if (swap_i) rd_data_o = {word[HALF-1:0], word[WORD_W-1:HALF]};
    else        rd_data_o = word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ridx_q <= '0;
    end else if (take_o) begin
      full_q <= 1'b1;
      ridx_q <= '0;
    end else if (clr_ok) begin
      full_q <= 1'b0;
      ridx_q <= '0;
    end else if (rd_ok) begin
      if (ridx_q == IDX_W'(DEPTH - 1)) begin
        full_q <= 1'b0;
        ridx_q <= '0;
      end else begin
        ridx_q <= ridx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_o) fifo_q <= blk_i;
  end

  assign full_o = full_q;

  p_load_sets_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (full_q && ridx_q == '0));

  p_empty_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && ridx_q == IDX_W'(DEPTH - 1) && !clr_ok) |=> !full_q);

  p_clr_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !eoc_i && !rd_ok && !take_o) |=> $stable(full_q));
endmodule

// File: rtl/rx_block_fifo.sv
module rx_block_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              pad_valid_i,
  input  logic [WORD_W-1:0] pad_data_i,
  output logic              pad_ready_o,
  input  logic              rd_i,
  input  logic              swap_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              stall_o,
  output logic              full_o,
  output logic              eoc_o,
  output logic [WORD_W-1:0] last_word_o
);
  logic [DEPTH-1:0][WORD_W-1:0] blk;
  logic                         blk_rdy, take;

  rbf_pad_fill #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (len_i),
    .pad_valid_i (pad_valid_i),
    .pad_data_i  (pad_data_i),
    .pad_ready_o (pad_ready_o),
    .take_i      (take),
    .blk_o       (blk),
    .blk_rdy_o   (blk_rdy),
    .eoc_o       (eoc_o),
    .last_word_o (last_word_o)
  );

  rbf_read_port #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_read (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blk_i     (blk),
    .blk_rdy_i (blk_rdy),
    .take_o    (take),
    .rd_i      (rd_i),
    .swap_i    (swap_i),
    .clr_i     (clr_i),
    .eoc_i     (eoc_o),
    .rd_data_o (rd_data_o),
    .stall_o   (stall_o),
    .full_o    (full_o)
  );
endmodule

// File: tb/rx_block_fifo_tb.sv
module rx_block_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] len = '0;
  logic        pad_valid = 1'b0;
  logic [15:0] pad_data = '0;
  logic        pad_ready;
  logic        rd = 1'b0;
  logic        swap = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] rd_data;
  logic        stall, full, eoc;
  logic [15:0] last_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_block_fifo u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .len_i       (len),
    .pad_valid_i (pad_valid),
    .pad_data_i  (pad_data),
    .pad_ready_o (pad_ready),
    .rd_i        (rd),
    .swap_i      (swap),
    .clr_i       (clr),
    .rd_data_o   (rd_data),
    .stall_o     (stall),
    .full_o      (full),
    .eoc_o       (eoc),
    .last_word_o (last_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bswap(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  // all tasks start and end at a falling edge
  task automatic begin_xfer(input logic [15:0] n);
    start = 1'b1; len = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    pad_valid = 1'b1; pad_data = d;
    #1;
    while (!pad_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    pad_valid = 1'b0;
    chk(last_word == d, "R9 last word tap", last_word, d);
  endtask

  task automatic pull(input logic [15:0] exp, input string tag);
    rd = 1'b1;
    #1;
    while (stall) begin @(negedge clk); #1; end
    chk(rd_data == exp, tag, rd_data, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset;
    chk(full == 1'b0, "R1 full after reset", 16'(full), 16'h0);
    chk(stall == 1'b0, "R1 stall after reset", 16'(stall), 16'h0);
    chk(eoc == 1'b1, "R1 eoc idle after reset", 16'(eoc), 16'h1);
    chk(pad_ready == 1'b0, "R1 pad_ready after reset", 16'(pad_ready), 16'h0);
  endtask

  task automatic t_long_xfer;
    begin_xfer(16'd32);
    chk(eoc == 1'b0, "R7 eoc low during transfer", 16'(eoc), 16'h0);
    for (int i = 0; i < 8; i++) push(16'h1000 + 16'(i));
    chk(full == 1'b0, "R2 full not yet set", 16'(full), 16'h0);
    @(negedge clk);
    chk(full == 1'b1, "R2 full after block load", 16'(full), 16'h1);
    // clear before end of transfer is ignored
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(full == 1'b1, "R8 clear ignored before eoc", 16'(full), 16'h1);
    // stage two more blocks while the FIFO holds the first
    for (int i = 8; i < 24; i++) push(16'h1000 + 16'(i));
    chk(pad_ready == 1'b0, "R10 both buffers full", 16'(pad_ready), 16'h0);
    pull(16'h1000, "R8 first word intact after ignored clear");
    for (int i = 1; i < 8; i++) pull(16'h1000 + 16'(i), "R4 R3 block 0 order");
    chk(full == 1'b0, "R3 empty after eighth read", 16'(full), 16'h0);
    chk(pad_ready == 1'b1, "R10 buffer free in copy cycle", 16'(pad_ready), 16'h1);
    @(negedge clk);
    chk(full == 1'b1, "R11 next buffer loaded", 16'(full), 16'h1);
    swap = 1'b1;
    for (int i = 8; i < 16; i++) pull(bswap(16'h1000 + 16'(i)), "R5 R11 swapped block 1");
    swap = 1'b0;
    for (int i = 16; i < 24; i++) pull(16'h1000 + 16'(i), "R11 block 2 from buffer 0");
    for (int i = 24; i < 32; i++) push(16'h1000 + 16'(i));
    chk(eoc == 1'b1, "R7 eoc after last word", 16'(eoc), 16'h1);
    chk(pad_ready == 1'b0, "R10 pad blocked after eoc", 16'(pad_ready), 16'h0);
    for (int i = 24; i < 32; i++) pull(16'h1000 + 16'(i), "R3 block 3 order");
  endtask

  task automatic t_short_stalled;
    int stalled = 0;
    begin_xfer(16'd3);
    fork
      begin
        rd = 1'b1;
        #1;
        chk(stall == 1'b1, "R6 stall on empty read", 16'(stall), 16'h1);
        while (stall) begin
          chk(full == 1'b0, "R6 stall only while not full", 16'(full), 16'h0);
          stalled++;
          @(negedge clk); #1;
        end
        chk(full == 1'b1, "R6 stall drops with full", 16'(full), 16'h1);
        chk(rd_data == 16'h2000, "R6 stalled read returns word 0", rd_data, 16'h2000);
        @(negedge clk);
        rd = 1'b0;
      end
      begin
        @(negedge clk);
        push(16'h2000);
        push(16'h2001);
        chk(eoc == 1'b0, "R7 eoc low before final word", 16'(eoc), 16'h0);
        push(16'h2002);
        chk(eoc == 1'b1, "R7 eoc at final word", 16'(eoc), 16'h1);
      end
    join
    chk(stalled > 2, "R6 reader was held", 16'(stalled), 16'h3);
    pull(16'h2001, "R7 partial block word 1");
    pull(16'h2002, "R7 partial block word 2");
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(full == 1'b0, "R8 clear after eoc empties", 16'(full), 16'h0);
    rd = 1'b1;
    #1;
    chk(stall == 1'b1, "R8 read stalls after clear", 16'(stall), 16'h1);
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_xfer();
    t_short_stalled();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule